// File: doc/BRIEF.md
# Bus-Read Clock and Data Port

This block is a small byte-wide register window on a CPU I/O bus. It decodes a 32-byte slice of the I/O space and, inside that slice, holds a handful of read/write scratch and control bytes, a status byte, a paired counter register with an odd write side effect, and a data port that streams a fixed 32-byte record one byte per read.

The record carries a time of day. The block keeps hours, minutes and seconds plus a sub-second tick counter. These do not run from a free time base. Every read of the data port counts as one tick, so software that polls the stream also drives the clock. The live seconds, minutes and hours occupy three fixed slots of the record, so the stream reports the current time.

The host loads the time of day through parallel preset inputs while reset is held. Addresses the block does not claim return an open-bus byte that the system supplies.

Top module: `rdclk_port`

## Requirements
- R1: A read at window offset 0x12 returns record byte [index], and the index then steps by one. The index goes from 31 back to 0. Write cycles and other reads leave the index alone, except as R5 states.
- R2: Each data-port read adds one tick. When the count reaches TICKS_PER_SEC it returns to 0 and seconds gain one. Without data-port reads, ticks and time fields hold.
- R3: On a data-port read, seconds at 60 or above become 0 and carry into minutes. Minutes at 60 or above become 0 and carry into hours. Hours at 24 or above become 0. All of this happens in the same update.
- R4: The record is fixed, except for the clock slots. Slots 5 and 6 read 0x01. Slots 13 through 22 read 0x0A. Slots 10, 11 and 12 read seconds, minutes and hours as they stand before the tick of that read. Every other slot reads 0x00.
- R5: Any write at offset 0x11 sets the index to 0. The written byte is not kept, and a read at 0x11 returns the open-bus byte.
- R6: A read at offset 0x13 returns the byte last written there, with bits 3 and 2 forced to 0.
- R7: The status byte at offset 0x10 reads 0x00 after reset. It becomes 0x80 on any write at offset 0x12 or offset 0x0F. Nothing else changes it.
- R8: A write of byte W at offset 0x0F does the following. The byte at 0x0E, with old value L, becomes W minus (L shifted right by one), modulo 256. The byte at 0x0F becomes W shifted right by one.
- R9: Offsets 0x08, 0x09, 0x0A, 0x0C, 0x0E, 0x14, 0x17 and 0x19 read back the last byte written to them.
- R10: A read outside the window, or at any window offset not named in R1 and R5 to R9, returns open_bus. The one exception is offset 0x16, which always reads 0x00. Writes to 0x0B and 0x16 change nothing that can be read.
- R11: Synchronous reset (rst_n low at a clock edge) does the following. It loads hours, minutes and seconds from the preset inputs. It clears the tick count, the index, rdata and all register bytes.
- R12: rdata is registered. It takes the read value at the clock edge where rd_en is high, and it holds whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | I/O address; the window is the 32 bytes at BASE_ADDR |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| open_bus | input | 8 | Byte returned for unclaimed reads |
| preset_hr | input | 8 | Hours loaded during reset |
| preset_min | input | 8 | Minutes loaded during reset |
| preset_sec | input | 8 | Seconds loaded during reset |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with TICKS_PER_SEC set to 3 and leaves the base address and the time-unit limits at their defaults. With three reads per second, a few dozen data-port reads are enough to cross minute, hour and midnight boundaries when they start from presets such as 23:59:59. A long stream of several hundred reads then checks every clock slot against a bench-side model over many seconds carries.

// File: rtl/rdclk_port.sv
`timescale 1ns/1ps
module rdclk_port #(
  parameter logic [15:0] BASE_ADDR     = 16'h2180,
  parameter int          TICKS_PER_SEC = 1000,
  parameter int          SEC_PER_MIN   = 60,
  parameter int          MIN_PER_HR    = 60,
  parameter int          HR_PER_DAY    = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  open_bus,
  input  logic [7:0]  preset_hr,
  input  logic [7:0]  preset_min,
  input  logic [7:0]  preset_sec,
  output logic [7:0]  rdata
);

  localparam int             TW       = $clog2(TICKS_PER_SEC + 1);
  localparam logic [TW:0]    TICK_LIM = (TW+1)'(TICKS_PER_SEC);
  localparam logic [8:0]     SEC_LIM  = 9'(SEC_PER_MIN);
  localparam logic [8:0]     MIN_LIM  = 9'(MIN_PER_HR);
  localparam logic [8:0]     HR_LIM   = 9'(HR_PER_DAY);

  localparam logic [4:0] A_SCR0   = 5'h08;
  localparam logic [4:0] A_SCR1   = 5'h09;
  localparam logic [4:0] A_SCR2   = 5'h0A;
  localparam logic [4:0] A_SCR3   = 5'h0C;
  localparam logic [4:0] A_CNT_LO = 5'h0E;
  localparam logic [4:0] A_CNT_HI = 5'h0F;
  localparam logic [4:0] A_STAT   = 5'h10;
  localparam logic [4:0] A_REWIND = 5'h11;
  localparam logic [4:0] A_DATA   = 5'h12;
  localparam logic [4:0] A_XSTAT  = 5'h13;
  localparam logic [4:0] A_CTRL   = 5'h14;
  localparam logic [4:0] A_RSVD   = 5'h16;
  localparam logic [4:0] A_AUX    = 5'h17;
  localparam logic [4:0] A_LINK   = 5'h19;

  localparam logic [4:0] SLOT_SEC = 5'd10;
  localparam logic [4:0] SLOT_MIN = 5'd11;
  localparam logic [4:0] SLOT_HR  = 5'd12;
  localparam logic [7:0] STAT_SET = 8'h80;
  localparam logic [7:0] XS_MASK  = 8'hF3;

  logic [7:0] scr0, scr1, scr2, scr3, cnt_lo, cnt_hi, stat, xstat, ctrl, aux, link;
  logic [4:0] idx;
  logic [TW-1:0] tick;
  logic [7:0] sec, mins, hr;

  logic       in_win, data_rd, wr_hit;
  logic [4:0] off;
  logic [7:0] buf_byte, rd_val;

  assign in_win  = (addr[15:5] == BASE_ADDR[15:5]);
  assign off     = addr[4:0];
  assign data_rd = rd_en & in_win & (off == A_DATA);
  assign wr_hit  = wr_en & in_win;

  always_comb begin
    buf_byte = 8'h00;
    if (idx == 5'd5 || idx == 5'd6)       buf_byte = 8'h01;
    else if (idx == SLOT_SEC)             buf_byte = sec;
    else if (idx == SLOT_MIN)             buf_byte = mins;
    else if (idx == SLOT_HR)              buf_byte = hr;
    else if (idx >= 5'd13 && idx <= 5'd22) buf_byte = 8'h0A;
  end

  logic [TW:0]   tick_inc;
  logic          tick_roll, sec_roll, min_roll;
  logic [8:0]    sec_inc, min_inc, hr_inc;
  logic [TW-1:0] tick_nx;
  logic [7:0]    sec_nx, min_nx, hr_nx;

  assign tick_inc  = (TW+1)'(tick) + (TW+1)'(1);
  assign tick_roll = (tick_inc >= TICK_LIM);
  assign tick_nx   = tick_roll ? '0 : tick_inc[TW-1:0];
  assign sec_inc   = 9'(sec) + 9'(tick_roll);
  assign sec_roll  = (sec_inc >= SEC_LIM);
  assign sec_nx    = sec_roll ? 8'h00 : sec_inc[7:0];
  assign min_inc   = 9'(mins) + 9'(sec_roll);
  assign min_roll  = (min_inc >= MIN_LIM);
  assign min_nx    = min_roll ? 8'h00 : min_inc[7:0];
  assign hr_inc    = 9'(hr) + 9'(min_roll);
  assign hr_nx     = (hr_inc >= HR_LIM) ? 8'h00 : hr_inc[7:0];

  always_comb begin
    rd_val = open_bus;
    if (in_win) begin
      case (off)
        A_SCR0:   rd_val = scr0;
        A_SCR1:   rd_val = scr1;
        A_SCR2:   rd_val = scr2;
        A_SCR3:   rd_val = scr3;
        A_CNT_LO: rd_val = cnt_lo;
        A_CNT_HI: rd_val = cnt_hi;
        A_STAT:   rd_val = stat;
        A_DATA:   rd_val = buf_byte;
        A_XSTAT:  rd_val = xstat & XS_MASK;
        A_CTRL:   rd_val = ctrl;
        A_RSVD:   rd_val = 8'h00;
        A_AUX:    rd_val = aux;
        A_LINK:   rd_val = link;
        default:  rd_val = open_bus;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr0 <= '0; scr1 <= '0; scr2 <= '0; scr3 <= '0;
      cnt_lo <= '0; cnt_hi <= '0; stat <= '0; xstat <= '0;
      ctrl <= '0; aux <= '0; link <= '0;
      idx <= '0; tick <= '0;
      sec <= preset_sec; mins <= preset_min; hr <= preset_hr;
      rdata <= '0;
    end else begin
      if (rd_en) rdata <= rd_val;
      if (data_rd) begin
        idx  <= idx + 5'd1;
        tick <= tick_nx;
        sec  <= sec_nx;
        mins <= min_nx;
        hr   <= hr_nx;
      end
      if (wr_hit) begin
        case (off)
          A_SCR0:   scr0  <= wdata;
          A_SCR1:   scr1  <= wdata;
          A_SCR2:   scr2  <= wdata;
          A_SCR3:   scr3  <= wdata;
          A_CNT_LO: cnt_lo <= wdata;
          A_CNT_HI: begin
            cnt_lo <= wdata - {1'b0, cnt_lo[7:1]};
            cnt_hi <= {1'b0, wdata[7:1]};
            stat   <= STAT_SET;
          end
          A_REWIND: idx   <= '0;
          A_DATA:   stat  <= STAT_SET;
          A_XSTAT:  xstat <= wdata;
          A_CTRL:   ctrl  <= wdata;
          A_AUX:    aux   <= wdata;
          A_LINK:   link  <= wdata;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rdclk_port_chk.sv
`timescale 1ns/1ps
module rdclk_port_chk #(
  parameter logic [15:0] BASE_ADDR     = 16'h2180,
  parameter int          TICKS_PER_SEC = 1000
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [15:0]                            addr,
  input logic                                   wr_en,
  input logic                                   rd_en,
  input logic [4:0]                             idx,
  input logic [$clog2(TICKS_PER_SEC + 1)-1:0]   tick,
  input logic [7:0]                             sec,
  input logic [7:0]                             mins,
  input logic [7:0]                             hr,
  input logic [7:0]                             stat,
  input logic [7:0]                             rdata
);
  localparam int TW = $clog2(TICKS_PER_SEC + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_SEC - 1);

  logic win, drd, rew_wr, stat_wr, last;
  assign win     = (addr[15:5] == BASE_ADDR[15:5]);
  assign drd     = rd_en && win && addr[4:0] == 5'h12;
  assign rew_wr  = wr_en && win && addr[4:0] == 5'h11;
  assign stat_wr = wr_en && win && (addr[4:0] == 5'h12 || addr[4:0] == 5'h0F);
  assign last    = (tick == TICK_LAST);

  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drd |=> idx == $past(idx) + 5'd1);

  assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!drd && !rew_wr) |=> $stable(idx));

  assert_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rew_wr |=> idx == 5'd0);

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && last && sec < 8'd59) |=> (sec == $past(sec) + 8'd1 && tick == '0));

  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drd |=> ($stable(tick) && $stable(sec) && $stable(mins) && $stable(hr)));

  assert_min_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && last && sec == 8'd59 && mins < 8'd59) |=> (sec == 8'd0 && mins == $past(mins) + 8'd1));

  assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && last && sec == 8'd59 && mins == 8'd59 && hr == 8'd23) |=> (hr == 8'd0 && mins == 8'd0));

  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> stat == 8'h80);

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(stat));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind rdclk_port rdclk_port_chk #(.BASE_ADDR(BASE_ADDR), .TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .idx(idx), .tick(tick), .sec(sec), .mins(mins), .hr(hr),
  .stat(stat), .rdata(rdata)
);

// File: tb/sim_rdclk_port.sv
`timescale 1ns/1ps
module sim_rdclk_port;
  localparam int TPS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  open_bus = 8'h5A;
  logic [7:0]  preset_hr = 8'h00, preset_min = 8'h00, preset_sec = 8'h00;
  logic [7:0]  rdata;

  always #2.5 clk = ~clk;

  rdclk_port #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .open_bus(open_bus), .preset_hr(preset_hr),
    .preset_min(preset_min), .preset_sec(preset_sec), .rdata(rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_idx, m_tick, m_s, m_m, m_h;

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_buf(int i);
    if (i == 5 || i == 6) return 8'h01;
    if (i == 10) return 8'(m_s);
    if (i == 11) return 8'(m_m);
    if (i == 12) return 8'(m_h);
    if (i >= 13 && i <= 22) return 8'h0A;
    return 8'h00;
  endfunction

  task automatic model_step();
    m_idx = (m_idx + 1) % 32;
    m_tick++;
    if (m_tick >= TPS) begin m_tick = 0; m_s++; end
    if (m_s >= 60) begin m_s = 0; m_m++; end
    if (m_m >= 60) begin m_m = 0; m_h++; end
    if (m_h >= 24) m_h = 0;
  endtask

  task automatic do_reset(int h, int m, int s);
    @(negedge clk);
    rst_n = 1'b0; preset_hr = 8'(h); preset_min = 8'(m); preset_sec = 8'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_idx = 0; m_tick = 0; m_h = h; m_m = m; m_s = s;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic data_rd_model(string req);
    logic [7:0] v;
    logic [7:0] e;
    e = exp_buf(m_idx);
    rd(16'h2192, v);
    check(req, v, e);
    model_step();
  endtask

  task automatic data_rd_lit(string req, logic [7:0] e);
    logic [7:0] v;
    rd(16'h2192, v);
    check(req, v, e);
    model_step();
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    do_reset(5, 6, 7);
    rd(16'h2190, v); check("R7 status after reset", v, 8'h00);
    rd(16'h2188, v); check("R11 scratch after reset", v, 8'h00);
    rd(16'h2193, v); check("R11 xstat after reset", v, 8'h00);
    rd(16'h2199, v); check("R11 link after reset", v, 8'h00);
    data_rd_lit("R11 index zero after reset", 8'h00);
  endtask

  task automatic t_plain_regs();
    logic [15:0] al[8] = '{16'h2188, 16'h2189, 16'h218A, 16'h218C,
                           16'h218E, 16'h2194, 16'h2197, 16'h2199};
    logic [7:0] v;
    for (int i = 0; i < 8; i++) wr(al[i], 8'(8'hA5 ^ (i * 17)));
    for (int i = 0; i < 8; i++) begin
      rd(al[i], v);
      check("R9 readback", v, 8'(8'hA5 ^ (i * 17)));
    end
  endtask

  task automatic t_xstat();
    logic [7:0] v;
    wr(16'h2193, 8'hFF); rd(16'h2193, v); check("R6 mask FF", v, 8'hF3);
    wr(16'h2193, 8'h0C); rd(16'h2193, v); check("R6 mask 0C", v, 8'h00);
    wr(16'h2193, 8'h35); rd(16'h2193, v); check("R6 mask 35", v, 8'h31);
  endtask

  task automatic t_open_bus();
    logic [15:0] al[6] = '{16'h2000, 16'h218B, 16'h2191, 16'h219A, 16'h2187, 16'h21A0};
    logic [7:0] v;
    open_bus = 8'h5A;
    for (int i = 0; i < 6; i++) begin
      rd(al[i], v);
      check("R10 open bus", v, 8'h5A);
    end
    open_bus = 8'hC3;
    wr(16'h218B, 8'h77);
    rd(16'h218B, v); check("R10 write-only offset reads open bus", v, 8'hC3);
    wr(16'h2196, 8'h44);
    rd(16'h2196, v); check("R10 offset 16 reads zero", v, 8'h00);
    open_bus = 8'h5A;
  endtask

  task automatic t_stream();
    do_reset(12, 34, 50);
    for (int i = 0; i < 32; i++) data_rd_model("R4 record slot");
    data_rd_lit("R1 index wraps to slot 0", 8'h00);
  endtask

  task automatic t_rewind();
    logic [7:0] v;
    do_reset(3, 4, 5);
    for (int i = 0; i < 5; i++) data_rd_model("R1 stream");
    wr(16'h2191, 8'h99);
    m_idx = 0;
    rd(16'h2191, v); check("R5 rewind byte not kept", v, open_bus);
    data_rd_lit("R5 rewind restarts at slot 0", 8'h00);
    for (int i = 1; i < 5; i++) data_rd_model("R4 record");
    data_rd_lit("R4 slot 5", 8'h01);
    data_rd_lit("R4 slot 6", 8'h01);
  endtask

  task automatic t_seconds();
    do_reset(1, 2, 3);
    for (int i = 0; i < 10; i++) data_rd_model("R2 stream");
    data_rd_lit("R2 seconds after 10 ticks", 8'd6);
    data_rd_lit("R2 minutes unchanged", 8'd2);
    data_rd_lit("R2 hours unchanged", 8'd1);
    do_reset(4, 10, 59);
    for (int i = 0; i < 10; i++) data_rd_model("R3 stream");
    data_rd_lit("R3 seconds after minute carry", 8'd2);
    data_rd_lit("R3 minutes carried", 8'd11);
    data_rd_lit("R3 hours unchanged", 8'd4);
  endtask

  task automatic t_midnight();
    do_reset(23, 59, 59);
    for (int i = 0; i < 10; i++) data_rd_model("R3 stream");
    data_rd_lit("R3 midnight seconds", 8'd2);
    data_rd_lit("R3 midnight minutes", 8'd0);
    data_rd_lit("R3 midnight hours", 8'd0);
  endtask

  task automatic t_long_run();
    do_reset(22, 58, 40);
    for (int i = 0; i < 420; i++) data_rd_model("R2 long stream");
  endtask

  task automatic t_cnt_pair();
    logic [7:0] v;
    do_reset(0, 0, 0);
    wr(16'h218E, 8'h40);
    wr(16'h218F, 8'h30);
    rd(16'h218E, v); check("R8 low after pair write", v, 8'h10);
    rd(16'h218F, v); check("R8 high after pair write", v, 8'h18);
    rd(16'h2190, v); check("R7 status after 0F write", v, 8'h80);
    wr(16'h218E, 8'h50);
    wr(16'h218F, 8'h10);
    rd(16'h218E, v); check("R8 low borrow", v, 8'hE8);
    rd(16'h218F, v); check("R8 high second", v, 8'h08);
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    do_reset(0, 0, 0);
    rd(16'h2190, v); check("R7 status clear", v, 8'h00);
    wr(16'h2192, 8'h33);
    rd(16'h2190, v); check("R7 status after data write", v, 8'h80);
    data_rd_lit("R1 data write leaves index", 8'h00);
  endtask

  task automatic t_rdata_hold();
    logic [7:0] v;
    wr(16'h2188, 8'h5C);
    wr(16'h2189, 8'h3E);
    rd(16'h2188, v); check("R12 read value", v, 8'h5C);
    @(negedge clk); addr = 16'h2189;
    repeat (3) @(negedge clk);
    check("R12 hold without strobe", rdata, 8'h5C);
    rd_en = 1'b1;
    #1 check("R12 no change before edge", rdata, 8'h5C);
    @(negedge clk); rd_en = 1'b0;
    check("R12 updates after edge", rdata, 8'h3E);
  endtask

  task automatic t_reset_again();
    logic [7:0] v;
    do_reset(9, 8, 7);
    rd(16'h2188, v); check("R11 registers cleared", v, 8'h00);
    rd(16'h2190, v); check("R11 status cleared", v, 8'h00);
    for (int i = 0; i < 10; i++) data_rd_model("R11 stream");
    data_rd_lit("R11 preset seconds plus ticks", 8'd10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_plain_regs();
    t_xstat();
    t_open_bus();
    t_stream();
    t_rewind();
    t_seconds();
    t_midnight();
    t_long_run();
    t_cnt_pair();
    t_data_write();
    t_rdata_hold();
    t_reset_again();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule